// File: doc/BRIEF.md
# Dual-Carrier Single-Converter Demodulator

This block recovers the complex envelopes of two RF probe signals that share one converter. The two signals are mixed down to separate intermediate frequencies, a 12 MHz carrier and an 8 MHz carrier. They are summed and sampled by a single 16-bit converter at 48 MHz. The block multiplies each accepted sample by a cosine and a sine reference for each carrier, and accumulates the products over a 12-sample window. That window is 250 ns long and holds exactly three periods of the 12 MHz carrier and two periods of the 8 MHz carrier. Over it, each carrier's correlation with the other carrier's references sums to exactly zero. A DC offset also sums to zero.

A high-Q cavity's envelope hardly moves within 250 ns, so each window gives one in-phase/quadrature pair per carrier. Because twelve samples add up, each result carries more resolution than a single sample. A sync input marks the start of an RF pulse and realigns the window to it.

The sequencing is a two-state machine. ST_IDLE discards samples until the first sync. Sync moves it to ST_ACC, which accumulates and emits a result pulse after every twelfth accepted sample. A further sync while in ST_ACC restarts the window in place. Only reset returns the machine to ST_IDLE.

Top module: `dif_demod`

## Requirements
- R1: While reset is asserted and after its release, `res_valid_o` is low and all four result outputs are zero until the first window completes.
- R2: Before the first cycle with `sync_i` high after reset, samples have no effect and `res_valid_o` stays low.
- R3: The 12 MHz results are `hi_i_o = sum x[k]*C12[k]` and `hi_q_o = sum x[k]*S12[k]` over window index k = 0..11, with C12[k mod 4] = {16384, 0, -16384, 0} and S12[k mod 4] = {0, 16384, 0, -16384}.
- R4: The 8 MHz results are `lo_i_o = sum x[k]*C8[k]` and `lo_q_o = sum x[k]*S8[k]`, with C8[k mod 6] = {16384, 8192, -8192, -16384, -8192, 8192} and S8[k mod 6] = {0, 14189, 14189, 0, -14189, -14189}.
- R5: A window holds 12 accepted samples. `res_valid_o` is high for exactly one cycle, the cycle after the clock edge that accepts the twelfth sample. From that edge on, the four results hold that window's sums.
- R6: A cycle with `smp_valid_i` low neither advances the window index nor changes any sum.
- R7: `sync_i` restarts the window. A sample accepted in the same cycle becomes index 0. The partial window in progress is dropped, and no result pulse is produced for it.
- R8: Any input with a period of 4 samples gives zero for both 8 MHz results. Any input with a period of 6 samples gives zero for both 12 MHz results. A constant input gives zero for all four results.
- R9: Between result pulses, all four result outputs keep their values.
- R10: A window of full-scale samples, -32768 and 32767, gives exact results without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_i | input | 1 | Pulse-start marker; restarts the window |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | 16 | Signed converter sample |
| res_valid_o | output | 1 | One-cycle pulse: new results available |
| hi_i_o | output | 36 | 12 MHz in-phase sum, signed |
| hi_q_o | output | 36 | 12 MHz quadrature sum, signed |
| lo_i_o | output | 36 | 8 MHz in-phase sum, signed |
| lo_q_o | output | 36 | 8 MHz quadrature sum, signed |

## Verification
The assertions assume that the parameter keeps the window length a multiple of 12, and so at least two samples long. They also assume that `sync_i` and `smp_valid_i` are never unknown after reset. The bound on result magnitude holds only for 16-bit signed input, which the sample port width fixes. The stimulus always drives both strobes to 0 or 1 at the falling edge. It uses random gaps and occasional random syncs. Directed windows add pure tones, DC, full-scale patterns, pre-sync traffic and a sync that cuts a window short.

// File: rtl/dif_pkg.sv
package dif_pkg;

    localparam int COEF_W    = 16;
    localparam int REF_FULL  = 16384;
    localparam int REF_HALF  = 8192;
    localparam int REF_SIN60 = 14189;

    typedef enum logic {
        ST_IDLE,
        ST_ACC
    } dif_state_e;

    typedef enum logic {
        CAR_12M,
        CAR_8M
    } carrier_e;

    // Cosine reference for the chosen carrier at window index k
    function automatic logic signed [COEF_W-1:0] ref_cos(carrier_e car, int unsigned k);
        int v;
        v = 0;
        if (car == CAR_12M) begin
            unique case (k % 4)
                0: v = REF_FULL;
                2: v = -REF_FULL;
                default: v = 0;
            endcase
        end else begin
            unique case (k % 6)
                0: v = REF_FULL;
                1: v = REF_HALF;
                2: v = -REF_HALF;
                3: v = -REF_FULL;
                4: v = -REF_HALF;
                default: v = REF_HALF;
            endcase
        end
        return COEF_W'(v);
    endfunction

    // Sine reference for the chosen carrier at window index k
    function automatic logic signed [COEF_W-1:0] ref_sin(carrier_e car, int unsigned k);
        int v;
        v = 0;
        if (car == CAR_12M) begin
            unique case (k % 4)
                1: v = REF_FULL;
                3: v = -REF_FULL;
                default: v = 0;
            endcase
        end else begin
            unique case (k % 6)
                1, 2: v = REF_SIN60;
                4, 5: v = -REF_SIN60;
                default: v = 0;
            endcase
        end
        return COEF_W'(v);
    endfunction

endpackage

// File: rtl/dif_window_fsm.sv
module dif_window_fsm
    import dif_pkg::*;
#(
    parameter int WIN_LEN = 12,
    localparam int IDX_W = $clog2(WIN_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_i,
    input  logic             smp_valid_i,
    output logic             acc_en_o,
    output logic             first_o,
    output logic             last_o,
    output logic [IDX_W-1:0] idx_o
);

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WIN_LEN - 1);

    dif_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [IDX_W-1:0] eff_idx;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // Next state: IDLE->ACC on sync; ACC stays (sync realigns in place)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (sync_i) state_d = ST_ACC;
            ST_ACC:  state_d = ST_ACC;
        endcase
    end

    // Outputs and window index
    always_comb begin
        eff_idx  = sync_i ? '0 : idx_q;
        acc_en_o = 1'b0;
        unique case (state_q)
            ST_IDLE: acc_en_o = smp_valid_i && sync_i;
            ST_ACC:  acc_en_o = smp_valid_i;
        endcase
        first_o = (eff_idx == '0);
        last_o  = (eff_idx == IDX_LAST);
        idx_o   = eff_idx;
        if (acc_en_o)
            idx_d = last_o ? '0 : eff_idx + 1'b1;
        else
            idx_d = eff_idx;
    end

endmodule

// File: rtl/dif_correlator.sv
module dif_correlator
    import dif_pkg::*;
#(
    parameter carrier_e CARRIER = CAR_12M,
    parameter int SMP_W   = 16,
    parameter int WIN_LEN = 12,
    localparam int IDX_W  = $clog2(WIN_LEN),
    localparam int PROD_W = SMP_W + COEF_W,
    localparam int ACC_W  = PROD_W + $clog2(WIN_LEN)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_en_i,
    input  logic                    first_i,
    input  logic                    last_i,
    input  logic [IDX_W-1:0]        idx_i,
    input  logic signed [SMP_W-1:0] smp_i,
    output logic signed [ACC_W-1:0] res_i_o,
    output logic signed [ACC_W-1:0] res_q_o
);

    logic signed [ACC_W-1:0] res_lane [2];

    // Lane 0 correlates with cosine, lane 1 with sine
    for (genvar lane = 0; lane < 2; lane++) begin : g_lane
        logic signed [COEF_W-1:0] coef;
        logic signed [PROD_W-1:0] prod;
        logic signed [ACC_W-1:0]  base, sum;
        logic signed [ACC_W-1:0]  acc_q, res_q;

        always_comb begin
            if (lane == 0) coef = ref_cos(CARRIER, int'(idx_i));
            else           coef = ref_sin(CARRIER, int'(idx_i));
            prod = smp_i * coef;
            base = first_i ? '0 : acc_q;
            sum  = base + ACC_W'(prod);
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc_q <= '0;
                res_q <= '0;
            end else if (acc_en_i) begin
                acc_q <= sum;
                if (last_i) res_q <= sum;
            end
        end

        assign res_lane[lane] = res_q;
    end

    assign res_i_o = res_lane[0];
    assign res_q_o = res_lane[1];

endmodule

// File: rtl/dif_demod.sv
module dif_demod
    import dif_pkg::*;
#(
    parameter int SMP_W   = 16,
    parameter int WIN_LEN = 12,
    localparam int ACC_W  = SMP_W + COEF_W + $clog2(WIN_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_i,
    input  logic             smp_valid_i,
    input  logic [SMP_W-1:0] smp_data_i,
    output logic             res_valid_o,
    output logic [ACC_W-1:0] hi_i_o,
    output logic [ACC_W-1:0] hi_q_o,
    output logic [ACC_W-1:0] lo_i_o,
    output logic [ACC_W-1:0] lo_q_o
);

    localparam int IDX_W = $clog2(WIN_LEN);

    logic             acc_en, first, last;
    logic [IDX_W-1:0] idx;
    logic             valid_q;

    dif_window_fsm #(.WIN_LEN(WIN_LEN)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_i      (sync_i),
        .smp_valid_i (smp_valid_i),
        .acc_en_o    (acc_en),
        .first_o     (first),
        .last_o      (last),
        .idx_o       (idx)
    );

    dif_correlator #(.CARRIER(CAR_12M), .SMP_W(SMP_W), .WIN_LEN(WIN_LEN)) hi_corr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_en_i (acc_en),
        .first_i  (first),
        .last_i   (last),
        .idx_i    (idx),
        .smp_i    ($signed(smp_data_i)),
        .res_i_o  (hi_i_o),
        .res_q_o  (hi_q_o)
    );

    dif_correlator #(.CARRIER(CAR_8M), .SMP_W(SMP_W), .WIN_LEN(WIN_LEN)) lo_corr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_en_i (acc_en),
        .first_i  (first),
        .last_i   (last),
        .idx_i    (idx),
        .smp_i    ($signed(smp_data_i)),
        .res_i_o  (lo_i_o),
        .res_q_o  (lo_q_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= acc_en && last;
    end

    assign res_valid_o = valid_q;

endmodule

// File: rtl/dif_demod_chk.sv
module dif_demod_chk #(
    parameter int SMP_W   = 16,
    parameter int WIN_LEN = 12,
    parameter int ACC_W   = 36
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sync_i,
    input logic             smp_valid_i,
    input logic             res_valid_o,
    input logic [ACC_W-1:0] hi_i_o,
    input logic [ACC_W-1:0] hi_q_o,
    input logic [ACC_W-1:0] lo_i_o,
    input logic [ACC_W-1:0] lo_q_o
);

    localparam int CNT_W = $clog2(WIN_LEN) + 1;
    localparam longint BOUND = longint'(WIN_LEN) * (longint'(1) << (SMP_W - 1)) * 16384;

    logic             seen_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            if (sync_i) seen_q <= 1'b1;
            if (sync_i || res_valid_o)
                cnt_q <= smp_valid_i ? CNT_W'(1) : '0;
            else if (seen_q && smp_valid_i)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    function automatic bit in_bound(logic [ACC_W-1:0] v);
        longint s;
        s = longint'($signed(v));
        return (s <= BOUND) && (s >= -BOUND);
    endfunction

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> !res_valid_o);                                          // R2
    AST_WINDOW_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> cnt_q == CNT_W'(WIN_LEN));                          // R5
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> !res_valid_o);                                      // R5
    AST_RESULTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid_o |-> $stable(hi_i_o) && $stable(hi_q_o)
                         && $stable(lo_i_o) && $stable(lo_q_o));            // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> in_bound(hi_i_o) && in_bound(hi_q_o)
                        && in_bound(lo_i_o) && in_bound(lo_q_o));           // R10

endmodule

bind dif_demod dif_demod_chk #(.SMP_W(SMP_W), .WIN_LEN(WIN_LEN), .ACC_W(ACC_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_i      (sync_i),
    .smp_valid_i (smp_valid_i),
    .res_valid_o (res_valid_o),
    .hi_i_o      (hi_i_o),
    .hi_q_o      (hi_q_o),
    .lo_i_o      (lo_i_o),
    .lo_q_o      (lo_q_o)
);

// File: tb/dif_demod_tb.sv
module dif_demod_tb_top;

    localparam int SMP_W = 16;
    localparam int WIN   = 12;
    localparam int ACC_W = 36;
    localparam real PI   = 3.14159265358979;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sync_i = 1'b0;
    logic             smp_valid_i = 1'b0;
    logic [SMP_W-1:0] smp_data_i = '0;
    logic             res_valid_o;
    logic [ACC_W-1:0] hi_i_o, hi_q_o, lo_i_o, lo_q_o;

    int checks = 0;
    int fails  = 0;

    int c12[12], s12[12], c8[12], s8[12];
    bit     started;
    int     idx;
    longint acc[4];
    longint held[4];

    always #4 clk = ~clk;

    dif_demod #(.SMP_W(SMP_W), .WIN_LEN(WIN)) dut_i (
        .clk (clk), .rst_n (rst_n), .sync_i (sync_i), .smp_valid_i (smp_valid_i),
        .smp_data_i (smp_data_i), .res_valid_o (res_valid_o),
        .hi_i_o (hi_i_o), .hi_q_o (hi_q_o), .lo_i_o (lo_i_o), .lo_q_o (lo_q_o)
    );

    function automatic longint sx(logic [ACC_W-1:0] v);
        return longint'($signed(v));
    endfunction

    task automatic check(input bit ok, input string tag, input string act, input string exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %s expected %s", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        started = 0; idx = 0;
        for (int j = 0; j < 4; j++) begin acc[j] = 0; held[j] = 0; end
    endtask

    // Drive one cycle at the falling edge, then compare outputs one cycle later
    task automatic step(input bit s, input bit v, input int x, input string tag);
        bit exp_v;
        longint a[4];
        string act_s, exp_s;
        sync_i = s; smp_valid_i = v; smp_data_i = SMP_W'(x);
        @(posedge clk);
        exp_v = 0;
        if (s) begin started = 1; idx = 0; for (int j = 0; j < 4; j++) acc[j] = 0; end
        if (started && v) begin
            acc[0] += longint'(x) * c12[idx];
            acc[1] += longint'(x) * s12[idx];
            acc[2] += longint'(x) * c8[idx];
            acc[3] += longint'(x) * s8[idx];
            idx++;
            if (idx == WIN) begin
                exp_v = 1; idx = 0;
                for (int j = 0; j < 4; j++) begin held[j] = acc[j]; acc[j] = 0; end
            end
        end
        @(negedge clk);
        sync_i = 0; smp_valid_i = 0;
        a[0] = sx(hi_i_o); a[1] = sx(hi_q_o); a[2] = sx(lo_i_o); a[3] = sx(lo_q_o);
        act_s = $sformatf("v=%0b %0d %0d %0d %0d", res_valid_o, a[0], a[1], a[2], a[3]);
        exp_s = $sformatf("v=%0b %0d %0d %0d %0d", exp_v, held[0], held[1], held[2], held[3]);
        check(res_valid_o == exp_v && a[0] == held[0] && a[1] == held[1]
              && a[2] == held[2] && a[3] == held[3], exp_v ? tag : {tag, "/R9"}, act_s, exp_s);
    endtask

    task automatic zero_check(input int which, input string tag);
        longint a0, a1;
        a0 = (which == 0) ? sx(hi_i_o) : sx(lo_i_o);
        a1 = (which == 0) ? sx(hi_q_o) : sx(lo_q_o);
        check(a0 == 0 && a1 == 0, tag, $sformatf("%0d %0d", a0, a1), "0 0");
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int dummy;
        dummy = $urandom(32'd1234);
        for (int k = 0; k < 12; k++) begin
            c12[k] = int'(16384.0 * $cos(2.0 * PI * k / 4.0));
            s12[k] = int'(16384.0 * $sin(2.0 * PI * k / 4.0));
            c8[k]  = int'(16384.0 * $cos(2.0 * PI * k / 6.0));
            s8[k]  = int'(16384.0 * $sin(2.0 * PI * k / 6.0));
        end
        model_reset();
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        check(res_valid_o == 0 && hi_i_o == 0 && hi_q_o == 0 && lo_i_o == 0 && lo_q_o == 0,
              "R1", $sformatf("v=%0b", res_valid_o), "all zero");
        rst_n = 1'b1;
        // R2: traffic before first sync is ignored
        for (int n = 0; n < 30; n++) step(0, 1, 20000 - n * 37, "R2");
        // R3/R4: impulse at each index identifies the tables
        for (int k = 0; k < 12; k++) begin
            for (int n = 0; n < 12; n++) step(n == 0, 1, (n == k) ? 1 : 0, "R3/R4");
        end
        // R8: 12 MHz tone -> 8 MHz outputs zero
        for (int n = 0; n < 12; n++)
            step(n == 0, 1, int'(20000.0 * $cos(2.0 * PI * n / 4.0 + 0.7)), "R3");
        zero_check(1, "R8");
        // R8: 8 MHz tone -> 12 MHz outputs zero
        for (int n = 0; n < 12; n++)
            step(n == 0, 1, int'(25000.0 * $sin(2.0 * PI * n / 6.0 + 1.3)), "R4");
        zero_check(0, "R8");
        // R8: DC -> all zero
        for (int n = 0; n < 12; n++) step(n == 0, 1, -12345, "R8");
        zero_check(0, "R8");
        zero_check(1, "R8");
        // R10: full-scale patterns matched to references
        for (int n = 0; n < 12; n++) step(n == 0, 1, (c8[n] < 0) ? 32767 : -32768, "R10");
        for (int n = 0; n < 12; n++) step(n == 0, 1, (s12[n] < 0) ? -32768 : 32767, "R10");
        for (int n = 0; n < 12; n++) step(n == 0, 1, -32768, "R10");
        // R7: sync cuts a partial window; sample with sync is index 0
        for (int n = 0; n < 5; n++) step(0, 1, 1000 * n, "R7");
        step(1, 1, 3000, "R7");
        for (int n = 0; n < 11; n++) step(0, 1, -700 * n, "R7");
        // R6: gaps do not advance the window
        for (int n = 0; n < 12; n++) begin
            step(0, 0, 31111, "R6");
            step(0, 1, 500 * n - 2000, "R6");
        end
        // Random traffic with gaps and occasional resyncs (R3, R4, R5, R6, R7)
        for (int n = 0; n < 6000; n++) begin
            bit s, v;
            s = ($urandom % 97) == 0;
            v = ($urandom % 4) != 0;
            step(s, v, int'($signed(16'($urandom))), "R5");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule